// File: doc/BRIEF.md
# Palette Framebuffer Control Register Block

This block is the register side of a palette-based framebuffer display controller. A host reaches it through a simple 32-bit word request port: one request strobe, a write flag, a word address and write data, answered by a one-cycle acknowledge that carries read data and an error flag. Behind the port sit a 256-entry colour lookup table, a three-colour cursor lookup table, a 512-word cursor bitmap, and registers for the visible size, the control word, the start offset of the picture in video memory and the cursor position.

Every stored value is presented to the scanout pipeline. Scanout gets its own read ports into the colour table and the cursor bitmap, and it reads the other values directly: size in pixels, blank and cursor-off flags, decoded pixel depth, start offset and cursor coordinates. Scanout reports the end of each frame with a pulse that raises the interrupt line. Any host write lowers that line.

A write to the soft-reset word zeroes every register at once. It then sweeps both tables back to zero, one entry per cycle. The hardware reset performs the same sweep. Host requests made during a sweep are held off until it ends. Writes to the video timing words are taken without error and change nothing.

Top module: `fbdac_regs`

## Requirements
- R1: A write to offset 0x800 + 8*i (i from 0 to 255) stores wdata[23:16] as red, wdata[15:8] as green and wdata[7:0] as blue for entry i. Presenting i on pal_idx shows {red,green,blue} on pal_rgb one cycle later.
- R2: The cursor colours sit at 0x508, 0x510 and 0x518 (entries 0, 1, 2) with the same packing as R1. Reading one returns {8'h00, rgb}. Entry k appears on curs_rgb[24k+23:24k].
- R3: The cursor bitmap word j (0 to 511) sits at 0x1000 + 8*j and stores wdata[15:0]. A read returns the word in bits 15:0 with zero above. Presenting j on curpat_idx shows the word on curpat_word one cycle later.
- R4: Writing v to 0x118 sets width_px to 4*v, and a read returns width_px/4. Writing v to 0x150 sets height_px to floor(v/2), and a read returns 2*height_px, so an odd v reads back one lower.
- R5: The control word at 0x300 reads back in full. Bit 10 drives blank and bit 23 drives cursor_off. Bits 22:20 = 0..7 give depth_bits = 1, 2, 4, 8, 15, 16, 0, 0.
- R6: A write to 0x400 loads top_offset from the low TOP_W bits. A write to 0x638 loads cursor_x from bits 23:12 and cursor_y from bits 11:0.
- R7: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 raise no error and change no output.
- R8: A read of any offset other than the cursor colours, the cursor bitmap, 0x118, 0x150 and 0x300 returns zero with acc_err high for the acknowledge cycle. A write to an offset in none of the regions of R1 to R7 and R11 also raises acc_err.
- R9: An accepted request gets exactly one acc_ack, one cycle after acceptance, with acc_rdata and acc_err valid in that cycle. acc_valid is held high until the acknowledge.
- R10: A frame_done pulse sets irq from the next cycle on. Every accepted write clears irq, visible with its acknowledge, and wins over a frame_done in the same cycle. Reads leave irq unchanged.
- R11: A write to 0x100000 is acknowledged and clears every register and irq. Both tables are then zeroed over 512 cycles, during which no request is acknowledged. The hardware reset does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host request, held until acknowledged |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the word |
| acc_wdata | input | 32 | Write data |
| acc_ack | output | 1 | One-cycle acknowledge |
| acc_rdata | output | 32 | Read data, valid with acc_ack |
| acc_err | output | 1 | Undecoded access, valid with acc_ack |
| frame_done | input | 1 | End-of-frame pulse from scanout |
| irq | output | 1 | Interrupt line |
| pal_idx | input | 8 | Scanout colour table index |
| pal_rgb | output | 24 | Colour of pal_idx, one cycle later |
| curpat_idx | input | 9 | Scanout cursor bitmap index |
| curpat_word | output | 16 | Bitmap word of curpat_idx, one cycle later |
| curs_rgb | output | 72 | Three cursor colours, entry 0 lowest |
| width_px | output | DIM_W | Visible width in pixels |
| height_px | output | DIM_W | Visible height in lines |
| blank | output | 1 | Force-blank flag |
| cursor_off | output | 1 | Cursor disable flag |
| depth_bits | output | 5 | Decoded bits per pixel |
| top_offset | output | TOP_W | Picture start offset in video memory |
| cursor_x | output | 12 | Cursor column |
| cursor_y | output | 12 | Cursor row |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a frame_done pulse and an accepted host write, which both act on irq. The bench raises irq, then drives frame_done and a write request on the same clock edge, and expects irq low when the acknowledge arrives. The second pair is the soft-reset sweep and host requests. The bench issues a request right after the reset write and judges it by its acknowledge: the acknowledge must be delayed by more than 500 cycles, and the read data it brings must be zero.

// File: rtl/fbdac_pkg.sv
// Shared constants, region codes and depth decode for the framebuffer
// control register block. Assumes 32-bit word accesses with byte offsets.
package fbdac_pkg;
    localparam int PAL_DEPTH = 256;
    localparam int PAT_DEPTH = 512;
    localparam int CUR_N     = 3;
    localparam int RGB_W     = 24;
    localparam int PAT_W     = 16;
    localparam int CPOS_FLD  = 12;
    localparam int PAL_AW    = $clog2(PAL_DEPTH);
    localparam int PAT_AW    = $clog2(PAT_DEPTH);
    localparam int STRIDE_SH = 3;

    localparam logic [31:0] OFS_PAL    = 32'h0000_0800;
    localparam logic [31:0] OFS_CURPAL = 32'h0000_0508;
    localparam logic [31:0] OFS_PAT    = 32'h0000_1000;
    localparam logic [31:0] OFS_WIDTH  = 32'h0000_0118;
    localparam logic [31:0] OFS_HEIGHT = 32'h0000_0150;
    localparam logic [31:0] OFS_CTRL   = 32'h0000_0300;
    localparam logic [31:0] OFS_TOP    = 32'h0000_0400;
    localparam logic [31:0] OFS_CPOS   = 32'h0000_0638;
    localparam logic [31:0] OFS_SRST   = 32'h0010_0000;

    localparam logic [31:0] SPAN_PAL    = 32'(PAL_DEPTH << STRIDE_SH);
    localparam logic [31:0] SPAN_CURPAL = 32'(CUR_N << STRIDE_SH);
    localparam logic [31:0] SPAN_PAT    = 32'(PAT_DEPTH << STRIDE_SH);

    typedef enum logic [3:0] {
        RG_NONE, RG_PAL, RG_CURPAL, RG_PAT, RG_WIDTH, RG_HEIGHT,
        RG_CTRL, RG_TOP, RG_CPOS, RG_TIMING, RG_SRST
    } fbdac_region_e;

    // Bits per pixel selected by the three-bit depth code
    function automatic logic [4:0] depth_of(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd15;
            3'd5:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction
endpackage

// File: rtl/fbdac_decode.sv
// Address decoder: maps a byte offset to a region and an entry index,
// and flags offsets that are not valid for the requested direction.
// Assumes ADDR_W <= 32. Purely combinational.
module fbdac_decode
    import fbdac_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               write,
    output fbdac_region_e      region,
    output logic [PAT_AW-1:0]  idx,
    output logic               undec
);
    logic [31:0] a;
    assign a = 32'(addr);

    // Region and index lookup
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (a >= OFS_PAL && a < OFS_PAL + SPAN_PAL) begin
            region = RG_PAL;
            idx    = PAT_AW'((a - OFS_PAL) >> STRIDE_SH);
        end else if (a >= OFS_PAT && a < OFS_PAT + SPAN_PAT) begin
            region = RG_PAT;
            idx    = PAT_AW'((a - OFS_PAT) >> STRIDE_SH);
        end else if (a >= OFS_CURPAL && a < OFS_CURPAL + SPAN_CURPAL) begin
            region = RG_CURPAL;
            idx    = PAT_AW'((a - OFS_CURPAL) >> STRIDE_SH);
        end else begin
            case (a)
                OFS_WIDTH:  region = RG_WIDTH;
                OFS_HEIGHT: region = RG_HEIGHT;
                OFS_CTRL:   region = RG_CTRL;
                OFS_TOP:    region = RG_TOP;
                OFS_CPOS:   region = RG_CPOS;
                OFS_SRST:   region = RG_SRST;
                32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130,
                32'h138, 32'h140, 32'h148, 32'h158, 32'h160, 32'h168,
                32'h170, 32'h200: region = RG_TIMING;
                default:    region = RG_NONE;
            endcase
        end
    end

    // Direction check: only some regions answer reads
    always_comb begin
        if (region == RG_NONE)
            undec = 1'b1;
        else if (!write)
            undec = !(region inside {RG_CURPAL, RG_PAT, RG_WIDTH, RG_HEIGHT, RG_CTRL});
        else
            undec = 1'b0;
    end
endmodule

// File: rtl/fbdac_sram.sv
// Simple synchronous RAM: one write port and NRD registered read ports.
// Contents are not reset; the owner clears them by writing.
module fbdac_sram #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 24,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [WIDTH-1:0]     wdata,
    input  logic [NRD*AW-1:0]    raddr,
    output logic [NRD*WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [WIDTH-1:0] q;
        // Registered read for reader g
        always_ff @(posedge clk) begin
            q <= mem[raddr[g*AW +: AW]];
        end
        assign rdata[g*WIDTH +: WIDTH] = q;
    end
endmodule

// File: rtl/fbdac_regs.sv
// Framebuffer control register block: host word port, colour and cursor
// tables, size/control/offset/cursor registers, interrupt line, and a
// clearing sweep after hardware or soft reset. Assumes the host holds
// acc_valid until acc_ack. Synchronous active-low reset.
module fbdac_regs
    import fbdac_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DIM_W  = 12,
    parameter int TOP_W  = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic                   acc_write,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [31:0]            acc_wdata,
    output logic                   acc_ack,
    output logic [31:0]            acc_rdata,
    output logic                   acc_err,
    input  logic                   frame_done,
    output logic                   irq,
    input  logic [PAL_AW-1:0]      pal_idx,
    output logic [RGB_W-1:0]       pal_rgb,
    input  logic [PAT_AW-1:0]      curpat_idx,
    output logic [PAT_W-1:0]       curpat_word,
    output logic [CUR_N*RGB_W-1:0] curs_rgb,
    output logic [DIM_W-1:0]       width_px,
    output logic [DIM_W-1:0]       height_px,
    output logic                   blank,
    output logic                   cursor_off,
    output logic [4:0]             depth_bits,
    output logic [TOP_W-1:0]       top_offset,
    output logic [CPOS_FLD-1:0]    cursor_x,
    output logic [CPOS_FLD-1:0]    cursor_y
);
    fbdac_region_e     region;
    logic [PAT_AW-1:0] idx;
    logic              undec;
    logic              accept, wr, rd;

    logic              clr_busy;
    logic [PAT_AW-1:0] clr_cnt;
    logic [RGB_W-1:0]  cur_pal [CUR_N];
    logic [31:0]       ctla_q;
    logic [2*CPOS_FLD-1:0] cpos_q;
    logic [31:0]       reg_rd, reg_q;
    logic              rd_pat_q;
    logic [PAT_W-1:0]  pat_acc_q;

    fbdac_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(acc_addr), .write(acc_write),
        .region(region), .idx(idx), .undec(undec)
    );

    assign accept = acc_valid && !clr_busy && !acc_ack;
    assign wr     = accept && acc_write;
    assign rd     = accept && !acc_write;

    // Colour table: written by host or the clearing sweep, read by scanout
    logic              pal_we;
    logic [PAL_AW-1:0] pal_wa;
    logic [RGB_W-1:0]  pal_wd;
    assign pal_we = clr_busy || (wr && region == RG_PAL);
    assign pal_wa = clr_busy ? clr_cnt[PAL_AW-1:0] : idx[PAL_AW-1:0];
    assign pal_wd = clr_busy ? '0 : acc_wdata[RGB_W-1:0];

    fbdac_sram #(.DEPTH(PAL_DEPTH), .WIDTH(RGB_W), .NRD(1)) u_pal (
        .clk(clk), .we(pal_we), .waddr(pal_wa), .wdata(pal_wd),
        .raddr(pal_idx), .rdata(pal_rgb)
    );

    // Cursor bitmap: reader 0 for the host, reader 1 for scanout
    logic              pat_we;
    logic [PAT_AW-1:0] pat_wa;
    logic [PAT_W-1:0]  pat_wd;
    assign pat_we = clr_busy || (wr && region == RG_PAT);
    assign pat_wa = clr_busy ? clr_cnt : idx;
    assign pat_wd = clr_busy ? '0 : acc_wdata[PAT_W-1:0];

    fbdac_sram #(.DEPTH(PAT_DEPTH), .WIDTH(PAT_W), .NRD(2)) u_pat (
        .clk(clk), .we(pat_we), .waddr(pat_wa), .wdata(pat_wd),
        .raddr({curpat_idx, idx}), .rdata({curpat_word, pat_acc_q})
    );

    // Read value of the register-type regions
    always_comb begin
        case (region)
            RG_CURPAL: reg_rd = 32'(cur_pal[idx[1:0]]);
            RG_WIDTH:  reg_rd = 32'(width_px >> 2);
            RG_HEIGHT: reg_rd = 32'({height_px, 1'b0});
            RG_CTRL:   reg_rd = ctla_q;
            default:   reg_rd = '0;
        endcase
    end

    // Handshake, interrupt, clearing sweep and register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_ack    <= 1'b0;
            acc_err    <= 1'b0;
            irq        <= 1'b0;
            clr_busy   <= 1'b1;
            clr_cnt    <= '0;
            for (int k = 0; k < CUR_N; k++) cur_pal[k] <= '0;
            width_px   <= '0;
            height_px  <= '0;
            ctla_q     <= '0;
            top_offset <= '0;
            cpos_q     <= '0;
            reg_q      <= '0;
            rd_pat_q   <= 1'b0;
        end else begin
            acc_ack  <= accept;
            acc_err  <= accept && undec;
            rd_pat_q <= rd && region == RG_PAT;
            reg_q    <= (rd && !undec) ? reg_rd : '0;
            if (wr)
                irq <= 1'b0;
            else if (frame_done)
                irq <= 1'b1;
            if (clr_busy) begin
                clr_cnt <= clr_cnt + 1'b1;
                if (clr_cnt == PAT_AW'(PAT_DEPTH - 1)) clr_busy <= 1'b0;
            end
            if (wr) begin
                case (region)
                    RG_CURPAL: cur_pal[idx[1:0]] <= acc_wdata[RGB_W-1:0];
                    RG_WIDTH:  width_px   <= {acc_wdata[DIM_W-3:0], 2'b00};
                    RG_HEIGHT: height_px  <= acc_wdata[DIM_W:1];
                    RG_CTRL:   ctla_q     <= acc_wdata;
                    RG_TOP:    top_offset <= acc_wdata[TOP_W-1:0];
                    RG_CPOS:   cpos_q     <= acc_wdata[2*CPOS_FLD-1:0];
                    RG_SRST: begin
                        for (int k = 0; k < CUR_N; k++) cur_pal[k] <= '0;
                        width_px   <= '0;
                        height_px  <= '0;
                        ctla_q     <= '0;
                        top_offset <= '0;
                        cpos_q     <= '0;
                        clr_busy   <= 1'b1;
                        clr_cnt    <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign acc_rdata  = rd_pat_q ? 32'(pat_acc_q) : reg_q;
    assign blank      = ctla_q[10];
    assign cursor_off = ctla_q[23];
    assign depth_bits = depth_of(ctla_q[22:20]);
    assign cursor_x   = cpos_q[2*CPOS_FLD-1:CPOS_FLD];
    assign cursor_y   = cpos_q[CPOS_FLD-1:0];

    for (genvar g = 0; g < CUR_N; g++) begin : g_curs
        assign curs_rgb[g*RGB_W +: RGB_W] = cur_pal[g];
    end
endmodule

// File: rtl/fbdac_regs_chk.sv
// Protocol and interrupt checker for fbdac_regs, attached by bind.
module fbdac_regs_chk #(
    parameter int DIM_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_write,
    input logic             acc_ack,
    input logic             acc_err,
    input logic             frame_done,
    input logic             irq,
    input logic             clr_busy,
    input logic [DIM_W-1:0] width_px,
    input logic [DIM_W-1:0] height_px
);
    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |=> !acc_ack);
    // R9
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ack |-> $past(acc_valid));
    // R8
    err_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> acc_ack);
    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_done));
    // R10
    irq_wr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ack && $past(acc_write)) |-> !irq);
    // R11
    clear_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && $past(clr_busy)) |-> !acc_ack);
    // R11
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_busy) |-> (width_px == '0 && height_px == '0 && !irq));
endmodule

bind fbdac_regs fbdac_regs_chk #(.DIM_W(DIM_W)) u_chk (.*);

// File: tb/fbdac_regs_test.sv
module fbdac_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [20:0] acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic        acc_ack, acc_err, irq, blank, cursor_off;
    logic [31:0] acc_rdata;
    logic        frame_done = 1'b0;
    logic [7:0]  pal_idx = '0;
    logic [23:0] pal_rgb;
    logic [8:0]  curpat_idx = '0;
    logic [15:0] curpat_word;
    logic [71:0] curs_rgb;
    logic [11:0] width_px, height_px, cursor_x, cursor_y;
    logic [4:0]  depth_bits;
    logic [23:0] top_offset;

    int nchk = 0, nerr = 0, cyc = 0;

    always #10 clk = ~clk;

    fbdac_regs uut (.*);

    // {write, addr, wdata, expected rdata, expected err}
    localparam int NV = 16;
    localparam logic [86:0] VEC [NV] = '{
        {1'b1, 21'h000808, 32'h0011_2233, 32'h0, 1'b0},
        {1'b1, 21'h000510, 32'h00AA_BBCC, 32'h0, 1'b0},
        {1'b0, 21'h000510, 32'h0, 32'h00AA_BBCC, 1'b0},
        {1'b1, 21'h001008, 32'hFFFF_BEEF, 32'h0, 1'b0},
        {1'b0, 21'h001008, 32'h0, 32'h0000_BEEF, 1'b0},
        {1'b1, 21'h000118, 32'h0000_0050, 32'h0, 1'b0},
        {1'b0, 21'h000118, 32'h0, 32'h0000_0050, 1'b0},
        {1'b1, 21'h000150, 32'h0000_01E1, 32'h0, 1'b0},
        {1'b0, 21'h000150, 32'h0, 32'h0000_01E0, 1'b0},
        {1'b1, 21'h000300, 32'h00B0_0400, 32'h0, 1'b0},
        {1'b0, 21'h000300, 32'h0, 32'h00B0_0400, 1'b0},
        {1'b0, 21'h000400, 32'h0, 32'h0, 1'b1},
        {1'b0, 21'h000004, 32'h0, 32'h0, 1'b1},
        {1'b1, 21'h000004, 32'h1234_5678, 32'h0, 1'b1},
        {1'b1, 21'h000108, 32'hFFFF_FFFF, 32'h0, 1'b0},
        {1'b0, 21'h000518, 32'h0, 32'h0, 1'b0}
    };

    function automatic string tag_of(input logic [20:0] a, input logic e);
        if (e) return "R8";
        if (a >= 21'h800 && a < 21'h1000) return "R1";
        if (a >= 21'h508 && a < 21'h520) return "R2";
        if (a >= 21'h1000 && a < 21'h2000) return "R3";
        if (a == 21'h118 || a == 21'h150) return "R4";
        if (a == 21'h300) return "R5";
        if (a == 21'h108) return "R7";
        return "R6";
    endfunction

    task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [20:0] a, input logic [31:0] d,
                          output logic [31:0] rdv, output logic e, output int waits);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_wdata = d;
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!acc_ack && waits < 2000);
        rdv = acc_rdata; e = acc_err;
        acc_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            $display("FAIL R9 watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [31:0] rdv;
        logic        e;
        int          waits;
        logic [71:0] snap;

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset irq", 72'(irq), 72'(0));
        chk("R11 reset ack", 72'(acc_ack), 72'(0));
        chk("R11 reset size", 72'({width_px, height_px}), 72'(0));
        rst_n = 1'b1;

        // Table walk; the first access also waits out the clearing sweep
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][86], VEC[i][85:65], VEC[i][64:33], rdv, e, waits);
            if (!VEC[i][86])
                chk(tag_of(VEC[i][85:65], VEC[i][0]), 72'(rdv), 72'(VEC[i][32:1]));
            chk(tag_of(VEC[i][85:65], VEC[i][0]), 72'(e), 72'(VEC[i][0]));
            if (i > 0) chk("R9 ack latency", 72'(waits), 72'(1));
        end

        // R1 and R3 scanout reads, registered by one cycle
        @(negedge clk); pal_idx = 8'd1; curpat_idx = 9'd1;
        @(negedge clk);
        chk("R1 scan colour", 72'(pal_rgb), 72'h112233);
        chk("R3 scan bitmap", 72'(curpat_word), 72'hBEEF);
        chk("R2 cursor colour", 72'(curs_rgb[47:24]), 72'hAABBCC);
        chk("R4 size", 72'({width_px, height_px}), 72'({12'd320, 12'd240}));
        // R5 control fields for code 3, cursor off, blank
        chk("R5 fields", 72'({blank, cursor_off, depth_bits}), 72'({1'b1, 1'b1, 5'd8}));
        access(1'b1, 21'h300, 32'h0050_0000, rdv, e, waits);
        chk("R5 depth code 5", 72'({blank, cursor_off, depth_bits}), 72'({1'b0, 1'b0, 5'd16}));
        access(1'b1, 21'h300, 32'h0060_0000, rdv, e, waits);
        chk("R5 depth code 6", 72'(depth_bits), 72'(0));

        // R6 offset and cursor position
        access(1'b1, 21'h400, 32'hFF01_2340, rdv, e, waits);
        access(1'b1, 21'h638, 32'h00AB_C123, rdv, e, waits);
        chk("R6 top", 72'(top_offset), 72'h012340);
        chk("R6 cursor", 72'({cursor_x, cursor_y}), 72'h00ABC123);

        // R7 timing words absorbed
        snap = 72'({width_px, height_px, depth_bits, blank, cursor_off, top_offset, cursor_x});
        access(1'b1, 21'h000, 32'hFFFF_FFFF, rdv, e, waits);
        chk("R7 err", 72'(e), 72'(0));
        access(1'b1, 21'h200, 32'hFFFF_FFFF, rdv, e, waits);
        access(1'b1, 21'h170, 32'hFFFF_FFFF, rdv, e, waits);
        chk("R7 unchanged", 72'({width_px, height_px, depth_bits, blank, cursor_off,
                                  top_offset, cursor_x}), snap);
        chk("R7 cursor y", 72'(cursor_y), 72'h123);

        // R10 frame pulse raises, read keeps, write lowers
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        chk("R10 raise", 72'(irq), 72'(1));
        access(1'b0, 21'h300, 32'h0, rdv, e, waits);
        chk("R10 read keeps", 72'(irq), 72'(1));
        access(1'b1, 21'h300, 32'h0, rdv, e, waits);
        chk("R10 write lowers", 72'(irq), 72'(0));

        // R10 collision: frame pulse and write on the same edge, write wins
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        chk("R10 raise again", 72'(irq), 72'(1));
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 21'h108; acc_wdata = '0;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        chk("R10 collision ack", 72'(acc_ack), 72'(1));
        chk("R10 collision irq", 72'(irq), 72'(0));
        acc_valid = 1'b0;

        // R11 soft reset and clearing sweep
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        access(1'b1, 21'h100000, 32'h0, rdv, e, waits);
        chk("R11 reset ack", 72'(waits), 72'(1));
        chk("R11 irq low", 72'(irq), 72'(0));
        chk("R11 regs zero", 72'({width_px, height_px, top_offset, cursor_x, cursor_y}), 72'(0));
        chk("R11 cursor colours", curs_rgb, 72'(0));
        chk("R11 depth code 0", 72'({blank, cursor_off, depth_bits}), 72'(1));
        access(1'b0, 21'h1008, 32'h0, rdv, e, waits);
        chk("R11 held off", 72'(waits > 500), 72'(1));
        chk("R11 bitmap cleared", 72'(rdv), 72'(0));
        @(negedge clk);
        chk("R11 scan colour cleared", 72'(pal_rgb), 72'(0));
        chk("R11 scan bitmap cleared", 72'(curpat_word), 72'(0));

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule